// File: doc/BRIEF.md
# Subranging Converter Back-End Sequencer and Overlap Corrector

This block is the digital half of a three-pass subranging analog-to-digital converter. A single bank of sixteen comparators is reused for three flash passes. Before the first pass the block captures a 2-bit coarse estimate. After every pass it reduces the comparator thermometer word to a count. Between the first and second passes it asks an external lookup port for a correction code, then holds that code steady for the correction DAC during the second pass.

The first pass is shifted down by an overlap band, so a coarse estimate that is one segment too high is repaired by decrementing it. The second pass fixes the tap interval to 10 bits. The third pass compares against levels that reach six LSBs below and six LSBs above that interval, and its count is applied as a signed offset. The 12-bit result is presented with a one-clock done strobe.

The analog front end drives `sel_pos` and supplies one comparator word per pass, each qualified by `cmp_valid`.

Top module: `subrange_merge`

## Requirements
- R1: `sel_pos` is 0 while idle. A `start` seen in idle captures `est_in` and moves `sel_pos` to 1 on the next cycle. `sel_pos` stays at 1 through the first pass and the lookup wait, then goes to 2 for the second pass and 3 for the third, always in that order.
- R2: Each comparator word is reduced to a count from 0 to 16. Bit 0 is the lowest level. Only the unbroken run of ones starting at bit 0 is counted, so any set bit above the first zero is ignored.
- R3: Let c1 be the first-pass count. When c1 < 4 (the lower overlap band), the coarse estimate is decremented and the 4-bit position becomes c1+12. Otherwise the estimate is kept and the position is c1−4. When the estimate is already 0 and c1 < 4, both fields become 0.
- R4: After the first-pass word is accepted, `lut_req` is high until a cycle with `lut_ack`. During that time `lut_addr` = {corrected estimate (bits 5:4), position (bits 3:0)} and stays constant.
- R5: `lut_code` is latched on the acknowledge cycle. `corr_code` carries the latched value from the next cycle on and stays unchanged through the whole second pass, whatever `lut_code` does afterwards.
- R6: The 10-bit intermediate is `lut_addr`×16 plus the second-pass count, where a count of 16 is treated as 15.
- R7: The final code is intermediate×4 plus the third-pass count minus 6, computed as a signed sum.
- R8: If that sum is below 0 the final code is 0, and if it is above 4095 the final code is 4095.
- R9: `done` is high for exactly one cycle, the cycle after the third-pass word is accepted. `code_out` changes only in that cycle and holds until the next conversion completes.
- R10: `cmp_valid` is ignored while idle and while waiting for `lut_ack`. `start` is ignored while a conversion is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Sample-and-begin request |
| est_in | input | 2 | Coarse voltage estimate |
| cmp_word | input | 16 | Comparator thermometer word, bit 0 lowest level |
| cmp_valid | input | 1 | `cmp_word` holds the current pass result |
| sel_pos | output | 2 | Analog input position: 0 idle, 1/2/3 for each pass |
| lut_req | output | 1 | Correction lookup request |
| lut_addr | output | 6 | Lookup address: corrected estimate and position |
| lut_ack | input | 1 | Lookup answer present on `lut_code` |
| lut_code | input | 8 | Correction code from the lookup |
| corr_code | output | 8 | Held correction code for the DAC |
| code_out | output | 12 | Final conversion result |
| done | output | 1 | One-cycle result strobe |

## Verification
The `done` strobe of one conversion can share a cycle with the `start` that opens the next one. This is the case where a faulty sequencer would drop the new request or repeat the strobe. The bench raises `start` with a fresh estimate in the very cycle it sees `done`. It then checks that `done` falls the next cycle, that `code_out` keeps the old result, and that `sel_pos` is already 1. The chained conversion must then produce a result computed from the new estimate.

// File: rtl/subrange_pkg.sv
package subrange_pkg;

   typedef enum logic [2:0] {
      SQ_IDLE  = 3'd0,
      SQ_PASS1 = 3'd1,
      SQ_LOOK  = 3'd2,
      SQ_PASS2 = 3'd3,
      SQ_PASS3 = 3'd4
   } sq_state_e;

   typedef struct packed {
      logic grab_est;
      logic grab_p1;
      logic grab_look;
      logic grab_p2;
      logic grab_p3;
   } sq_strobe_t;

endpackage

// File: rtl/sr_thermo_count.sv
module sr_thermo_count #(
   parameter int NCMP = 16,
   localparam int CNT_W = $clog2(NCMP + 1)
) (
   input  logic [NCMP-1:0]  word,
   output logic [CNT_W-1:0] count
);

   logic [NCMP-1:0] run;

   assign run[0] = word[0];

   generate
      for (genvar gi = 1; gi < NCMP; gi++) begin : g_chain
         assign run[gi] = run[gi-1] & word[gi];
      end
   endgenerate

   always_comb begin
      count = '0;
      for (int k = 0; k < NCMP; k++) begin
         count = count + CNT_W'(run[k]);
      end
   end

endmodule

// File: rtl/sr_sequencer.sv
module sr_sequencer
   import subrange_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       start,
   input  logic       cmp_valid,
   input  logic       lut_ack,
   output logic [1:0] sel_pos,
   output logic       lut_req,
   output sq_strobe_t strobe
);

   sq_state_e state_q, state_d;

   always_comb begin
      strobe.grab_est  = (state_q == SQ_IDLE)  && start;
      strobe.grab_p1   = (state_q == SQ_PASS1) && cmp_valid;
      strobe.grab_look = (state_q == SQ_LOOK)  && lut_ack;
      strobe.grab_p2   = (state_q == SQ_PASS2) && cmp_valid;
      strobe.grab_p3   = (state_q == SQ_PASS3) && cmp_valid;
   end

   always_comb begin
      state_d = state_q;
      unique case (state_q)
         SQ_IDLE:  if (strobe.grab_est)  state_d = SQ_PASS1;
         SQ_PASS1: if (strobe.grab_p1)   state_d = SQ_LOOK;
         SQ_LOOK:  if (strobe.grab_look) state_d = SQ_PASS2;
         SQ_PASS2: if (strobe.grab_p2)   state_d = SQ_PASS3;
         SQ_PASS3: if (strobe.grab_p3)   state_d = SQ_IDLE;
         default:                        state_d = SQ_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) state_q <= SQ_IDLE;
      else        state_q <= state_d;
   end

   always_comb begin
      unique case (state_q)
         SQ_PASS1, SQ_LOOK: sel_pos = 2'd1;
         SQ_PASS2:          sel_pos = 2'd2;
         SQ_PASS3:          sel_pos = 2'd3;
         default:           sel_pos = 2'd0;
      endcase
   end

   assign lut_req = (state_q == SQ_LOOK);

endmodule

// File: rtl/sr_combine.sv
module sr_combine
   import subrange_pkg::*;
#(
   parameter int NCMP      = 16,
   parameter int EST_W     = 2,
   parameter int CORR_W    = 8,
   parameter int LOW_BAND  = 4,
   parameter int BELOW     = 6,
   parameter int FINE_W    = 2,
   localparam int CNT_W    = $clog2(NCMP + 1),
   localparam int FL_W     = $clog2(NCMP),
   localparam int ADDR_W   = EST_W + FL_W,
   localparam int MID_W    = ADDR_W + FL_W,
   localparam int CODE_W   = MID_W + FINE_W,
   localparam int SUM_W    = CODE_W + 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  sq_strobe_t        strobe,
   input  logic [EST_W-1:0]  est_in,
   input  logic [CNT_W-1:0]  count,
   input  logic [CORR_W-1:0] lut_code,
   output logic [ADDR_W-1:0] lut_addr,
   output logic [CORR_W-1:0] corr_code,
   output logic [CODE_W-1:0] code_out,
   output logic              done
);

   logic [EST_W-1:0]  est_q;
   logic [ADDR_W-1:0] addr_q;
   logic [MID_W-1:0]  mid_q;
   logic [CORR_W-1:0] corr_q;
   logic [CODE_W-1:0] code_q;
   logic              done_q;

   // pass 1 overlap fold
   logic [EST_W-1:0] est_fix;
   logic [FL_W-1:0]  pos_fix;

   always_comb begin
      est_fix = est_q;
      pos_fix = '0;
      if (count < CNT_W'(LOW_BAND)) begin
         if (est_q == '0) begin
            est_fix = '0;
            pos_fix = '0;
         end else begin
            est_fix = est_q - EST_W'(1);
            pos_fix = FL_W'(count + CNT_W'(NCMP - LOW_BAND));
         end
      end else begin
         pos_fix = FL_W'(count - CNT_W'(LOW_BAND));
      end
   end

   // pass 2 clamp
   logic [FL_W-1:0] fine_cnt;
   assign fine_cnt = (count >= CNT_W'(NCMP)) ? FL_W'(NCMP - 1) : count[FL_W-1:0];

   // pass 3 signed merge and saturation
   logic [SUM_W-1:0]  sum;
   logic [CODE_W-1:0] sat_code;

   always_comb begin
      sum = SUM_W'({mid_q, {FINE_W{1'b0}}}) + SUM_W'(count) - SUM_W'(BELOW);
      if (sum[SUM_W-1])
         sat_code = '0;
      else if (sum[SUM_W-2:CODE_W] != '0)
         sat_code = '1;
      else
         sat_code = sum[CODE_W-1:0];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         est_q  <= '0;
         addr_q <= '0;
         mid_q  <= '0;
         corr_q <= '0;
         code_q <= '0;
         done_q <= 1'b0;
      end else begin
         done_q <= strobe.grab_p3;
         if (strobe.grab_est)  est_q  <= est_in;
         if (strobe.grab_p1)   addr_q <= {est_fix, pos_fix};
         if (strobe.grab_look) corr_q <= lut_code;
         if (strobe.grab_p2)   mid_q  <= {addr_q, fine_cnt};
         if (strobe.grab_p3)   code_q <= sat_code;
      end
   end

   assign lut_addr  = addr_q;
   assign corr_code = corr_q;
   assign code_out  = code_q;
   assign done      = done_q;

endmodule

// File: rtl/subrange_merge.sv
module subrange_merge
   import subrange_pkg::*;
#(
   parameter int NCMP        = 16,
   parameter int EST_W       = 2,
   parameter int CORR_W      = 8,
   parameter int LOW_BAND    = 4,
   parameter int BELOW       = 6,
   parameter int FINE_STEPS  = 4,
   localparam int FINE_W     = $clog2(FINE_STEPS),
   localparam int FL_W       = $clog2(NCMP),
   localparam int CNT_W      = $clog2(NCMP + 1),
   localparam int ADDR_W     = EST_W + FL_W,
   localparam int CODE_W     = ADDR_W + FL_W + FINE_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [EST_W-1:0]  est_in,
   input  logic [NCMP-1:0]   cmp_word,
   input  logic              cmp_valid,
   output logic [1:0]        sel_pos,
   output logic              lut_req,
   output logic [ADDR_W-1:0] lut_addr,
   input  logic              lut_ack,
   input  logic [CORR_W-1:0] lut_code,
   output logic [CORR_W-1:0] corr_code,
   output logic [CODE_W-1:0] code_out,
   output logic              done
);

   generate
      if ((1 << FL_W) != NCMP) begin : g_bad_ncmp
         $error("NCMP must be a power of two");
      end
      if ((1 << FINE_W) != FINE_STEPS) begin : g_bad_fine
         $error("FINE_STEPS must be a power of two");
      end
      if (NCMP != 2 * BELOW + FINE_STEPS) begin : g_bad_span
         $error("third-pass levels must equal comparator count");
      end
      if (LOW_BAND < 1 || LOW_BAND >= NCMP) begin : g_bad_band
         $error("LOW_BAND out of range");
      end
   endgenerate

   sq_strobe_t       strobe;
   logic [CNT_W-1:0] count;

   sr_thermo_count #(.NCMP(NCMP)) u_count (
      .word  (cmp_word),
      .count (count)
   );

   sr_sequencer u_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .start     (start),
      .cmp_valid (cmp_valid),
      .lut_ack   (lut_ack),
      .sel_pos   (sel_pos),
      .lut_req   (lut_req),
      .strobe    (strobe)
   );

   sr_combine #(
      .NCMP     (NCMP),
      .EST_W    (EST_W),
      .CORR_W   (CORR_W),
      .LOW_BAND (LOW_BAND),
      .BELOW    (BELOW),
      .FINE_W   (FINE_W)
   ) u_comb (
      .clk       (clk),
      .rst_n     (rst_n),
      .strobe    (strobe),
      .est_in    (est_in),
      .count     (count),
      .lut_code  (lut_code),
      .lut_addr  (lut_addr),
      .corr_code (corr_code),
      .code_out  (code_out),
      .done      (done)
   );

endmodule

// File: rtl/subrange_merge_chk.sv
module subrange_merge_chk #(
   parameter int ADDR_W = 6,
   parameter int CORR_W = 8,
   parameter int CODE_W = 12
) (
   input logic              clk,
   input logic              rst_n,
   input logic [1:0]        sel_pos,
   input logic              lut_req,
   input logic [ADDR_W-1:0] lut_addr,
   input logic [CORR_W-1:0] corr_code,
   input logic [CODE_W-1:0] code_out,
   input logic              done
);

   // R1: positions advance one step at a time
   p_sel_order_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (sel_pos != $past(sel_pos) && sel_pos != 2'd0) |-> (sel_pos == $past(sel_pos) + 2'd1));

   // R4: lookup address steady while waiting
   p_addr_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (lut_req && $past(lut_req)) |-> $stable(lut_addr));

   // R5: correction code steady during pass 2
   p_corr_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (sel_pos == 2'd2 && $past(sel_pos) == 2'd2) |-> $stable(corr_code));

   // R9: single-cycle strobe
   p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   // R9: strobe only after pass 3
   p_done_after_p3_r9: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> ($past(sel_pos) == 2'd3));

   // R9: result changes only with the strobe
   p_code_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !done |-> $stable(code_out));

endmodule

bind subrange_merge subrange_merge_chk #(
   .ADDR_W (ADDR_W),
   .CORR_W (CORR_W),
   .CODE_W (CODE_W)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .sel_pos   (sel_pos),
   .lut_req   (lut_req),
   .lut_addr  (lut_addr),
   .corr_code (corr_code),
   .code_out  (code_out),
   .done      (done)
);

// File: tb/subrange_merge_bench.sv
module subrange_merge_bench;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic [1:0]  est_in = '0;
   logic [15:0] cmp_word = '0;
   logic        cmp_valid = 1'b0;
   logic [1:0]  sel_pos;
   logic        lut_req;
   logic [5:0]  lut_addr;
   logic        lut_ack = 1'b0;
   logic [7:0]  lut_code = '0;
   logic [7:0]  corr_code;
   logic [11:0] code_out;
   logic        done;

   int n_run = 0;
   int n_fail = 0;
   bit finished = 1'b0;

   always #2 clk = ~clk;

   subrange_merge u_subrange_merge (
      .clk       (clk),
      .rst_n     (rst_n),
      .start     (start),
      .est_in    (est_in),
      .cmp_word  (cmp_word),
      .cmp_valid (cmp_valid),
      .sel_pos   (sel_pos),
      .lut_req   (lut_req),
      .lut_addr  (lut_addr),
      .lut_ack   (lut_ack),
      .lut_code  (lut_code),
      .corr_code (corr_code),
      .code_out  (code_out),
      .done      (done)
   );

   task automatic chk(input string req, input string what, input int act, input int exp);
      n_run++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   function automatic logic [15:0] therm(input int n);
      logic [16:0] t;
      t = (17'd1 << n) - 17'd1;
      return t[15:0];
   endfunction

   function automatic int lead(input logic [15:0] w);
      int n = 0;
      for (int i = 0; i < 16; i++) if (w[i] && n == i) n++;
      return n;
   endfunction

   function automatic int exp_addr(input int est, input logic [15:0] w1);
      int v = est * 16 + lead(w1) - 4;
      return (v < 0) ? 0 : v;
   endfunction

   function automatic int exp_code(input int est, input logic [15:0] w1,
                                   input logic [15:0] w2, input logic [15:0] w3);
      int c2 = lead(w2);
      int mid;
      int f;
      if (c2 > 15) c2 = 15;
      mid = exp_addr(est, w1) * 16 + c2;
      f = mid * 4 + lead(w3) - 6;
      if (f < 0) f = 0;
      if (f > 4095) f = 4095;
      return f;
   endfunction

   // one conversion; all driving and sampling on falling edges
   task automatic run_conv(input string req, input int est, input logic [15:0] w1,
                           input logic [15:0] w2, input logic [15:0] w3,
                           input logic [7:0] lc, input int ack_delay,
                           input bit poke_start, input bit skip_start, input int next_est);
      int exp = exp_code(est, w1, w2, w3);
      if (!skip_start) begin
         start = 1'b1; est_in = 2'(est);
         @(negedge clk);
         start = 1'b0;
      end
      chk("R1", "pass1 position", int'(sel_pos), 1);
      cmp_word = w1; cmp_valid = 1'b1;
      @(negedge clk);
      cmp_valid = 1'b0;
      chk("R4", "lookup request", int'(lut_req), 1);
      chk("R3", "lookup address", int'(lut_addr), exp_addr(est, w1));
      for (int d = 0; d < ack_delay; d++) begin
         cmp_word = 16'hFFFF; cmp_valid = 1'b1;
         @(negedge clk);
         cmp_valid = 1'b0;
         chk("R10", "valid ignored in lookup wait", int'(sel_pos), 1);
         chk("R4", "address held in wait", int'(lut_addr), exp_addr(est, w1));
      end
      lut_ack = 1'b1; lut_code = lc;
      @(negedge clk);
      lut_ack = 1'b0; lut_code = ~lc;
      chk("R1", "pass2 position", int'(sel_pos), 2);
      chk("R5", "correction latched", int'(corr_code), int'(lc));
      if (poke_start) begin
         start = 1'b1; est_in = ~2'(est);
         @(negedge clk);
         start = 1'b0;
         chk("R10", "start ignored in pass2", int'(sel_pos), 2);
      end
      cmp_word = w2; cmp_valid = 1'b1;
      @(negedge clk);
      cmp_valid = 1'b0;
      chk("R1", "pass3 position", int'(sel_pos), 3);
      chk("R5", "correction held", int'(corr_code), int'(lc));
      cmp_word = w3; cmp_valid = 1'b1;
      @(negedge clk);
      cmp_valid = 1'b0;
      chk("R9", "done strobe", int'(done), 1);
      chk(req, "final code", int'(code_out), exp);
      if (next_est >= 0) begin
         start = 1'b1; est_in = 2'(next_est);
      end
      @(negedge clk);
      start = 1'b0;
      chk("R9", "done falls", int'(done), 0);
      chk("R9", "code held", int'(code_out), exp);
   endtask

   task automatic t_reset;
      chk("R1", "reset position", int'(sel_pos), 0);
      chk("R9", "reset done", int'(done), 0);
      chk("R4", "reset request", int'(lut_req), 0);
      chk("R9", "reset code", int'(code_out), 0);
      chk("R5", "reset correction", int'(corr_code), 0);
   endtask

   task automatic t_basic;       // R6 R7: 37*16+7=599 -> 2396+2=2398
      run_conv("R7", 2, therm(9), therm(7), therm(8), 8'h5A, 0, 0, 0, -1);
      chk("R6", "basic value", int'(code_out), 2398);
   endtask

   task automatic t_lower_band;  // R3: est 2, c1=2 -> addr 30
      run_conv("R3", 2, therm(2), therm(15), therm(6), 8'hC3, 0, 0, 0, -1);
      chk("R3", "decremented result", int'(code_out), 1980);
   endtask

   task automatic t_bubble;      // R2: bits above first zero ignored
      run_conv("R2", 1, therm(10) | 16'h3000, therm(3) | 16'h0100,
               therm(5) | 16'h8000, 8'h11, 0, 0, 0, -1);
   endtask

   task automatic t_underflow;   // R8: sum -4 -> 0
      run_conv("R8", 0, therm(1), therm(0), therm(2), 8'h22, 0, 0, 0, -1);
      chk("R8", "clamped low", int'(code_out), 0);
   endtask

   task automatic t_full_words;  // R6: count 16 treated as 15; 975*4+10
      run_conv("R6", 3, therm(16), therm(16), therm(16), 8'hFF, 0, 0, 0, -1);
      chk("R6", "full words", int'(code_out), 3910);
   endtask

   task automatic t_ignore;      // R10
      for (int i = 0; i < 3; i++) begin
         cmp_word = 16'hFFFF; cmp_valid = 1'b1;
         @(negedge clk);
         cmp_valid = 1'b0;
         chk("R10", "idle valid ignored", int'(sel_pos), 0);
         chk("R10", "idle no done", int'(done), 0);
      end
      run_conv("R10", 1, therm(6), therm(4), therm(9), 8'h3C, 3, 1, 0, -1);
   endtask

   task automatic t_back_to_back; // R9 strobe and new start share a cycle
      run_conv("R9", 2, therm(12), therm(1), therm(7), 8'h44, 0, 0, 0, 3);
      chk("R1", "chained start accepted", int'(sel_pos), 1);
      run_conv("R9", 3, therm(5), therm(11), therm(10), 8'h99, 0, 0, 1, -1);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_basic();
      t_lower_band();
      t_bubble();
      t_underflow();
      t_full_words();
      t_ignore();
      t_back_to_back();
      if (!finished) begin
         finished = 1'b1;
         $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!finished) begin
         finished = 1'b1;
         n_run++;
         n_fail++;
         $display("FAIL R1 watchdog: actual=hung expected=complete");
         $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

endmodule